// File: doc/BRIEF.md
# Wrapping Register Stack

A last-in, first-out store of 2^ADDR_W words held in flip-flops. Each cycle it takes one command, either a push strobe with a word on the write-data input or a pop strobe. A pop copies the top word into an output data register. A stack pointer of ADDR_W bits always addresses the top item and wraps modulo the depth. The pointer starts at 0 and a push increments it before writing, so the first item lands in word 1. The last item that fits lands in word 0.

Two one-bit status registers show the fill state. There is no occupancy counter behind them. The full flag is set when a push moves the pointer onto 0. The empty flag is set when a pop moves the pointer onto 0. The block refuses a push while full, a pop while empty, or both strobes in the same cycle. A refused request changes no state and raises a one-cycle error pulse.

Top module: `wrap_reg_stack`

## Requirements
- R1: After the asynchronous reset, empty_o is 1, full_o is 0, err_o is 0 and rdata_o is all zeros. The pointer is 0, so the first push writes word 1.
- R2: Commands are sampled on the rising clock edge and take effect on that edge. A legal pop (pop_i=1, push_i=0, empty_o=0) puts the most recently pushed word that has not yet been popped on rdata_o after that edge.
- R3: rdata_o changes only on a legal pop. Pushes, idle cycles and refused requests leave it unchanged.
- R4: Every legal push clears empty_o. A legal pop that brings the pointer back to 0 sets empty_o. This is the pop that removes the first item stored.
- R5: The push that stores the 2^ADDR_W-th item moves the pointer from its maximum value to 0 and sets full_o. full_o is 1 only while the pointer is 0.
- R6: A legal pop clears full_o. After a full stack, pops return all 2^ADDR_W items in reverse order of pushing, starting with the item stored in word 0.
- R7: A push while full_o=1 is refused. Flags and contents are unchanged and err_o is 1 in the following cycle.
- R8: A pop while empty_o=1 is refused. Flags and rdata_o are unchanged and err_o is 1 in the following cycle.
- R9: If push_i and pop_i are both 1 in the same cycle, both are ignored, state is unchanged and err_o pulses.
- R10: err_o is a registered pulse that lasts one cycle per refused request. It is 0 after any legal or idle cycle.
- R11: The pointer, the flags and the stored words hold through idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push command strobe |
| pop_i | input | 1 | Pop command strobe |
| wdata_i | input | DATA_W | Word to push |
| rdata_o | output | DATA_W | Data register, last popped word |
| full_o | output | 1 | Stack holds 2^ADDR_W items |
| empty_o | output | 1 | Stack holds no items |
| err_o | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench builds the block with DATA_W=16 and ADDR_W=6, so it checks the full 64-word depth. Sixty-four back-to-back pushes are enough to take the pointer through its 63-to-0 wrap and raise the full flag. The following pops cross the same boundary in the other direction, starting from word 0. The word width lets every stored word carry its own index, so a misplaced write or read shows up as a wrong value rather than passing unnoticed.

// File: rtl/wstk_pkg.sv
`timescale 1ns/1ps
package wstk_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_PUSH    = 2'b01,
    OP_POP     = 2'b10,
    OP_ILLEGAL = 2'b11
  } stk_op_e;
endpackage

// File: rtl/wstk_op_dec.sv
`timescale 1ns/1ps
module wstk_op_dec
  import wstk_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    full_i,
  input  logic    empty_i,
  output stk_op_e op_o
);
  always_comb begin
    unique case ({pop_i, push_i})
      2'b00:   op_o = OP_NONE;
      2'b01:   op_o = full_i  ? OP_ILLEGAL : OP_PUSH;
      2'b10:   op_o = empty_i ? OP_ILLEGAL : OP_POP;
      default: op_o = OP_ILLEGAL;  // simultaneous strobes
    endcase
  end
endmodule

// File: rtl/wstk_ptr.sv
`timescale 1ns/1ps
module wstk_ptr
  import wstk_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stk_op_e           op_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [ADDR_W-1:0] sp_q, sp_inc, sp_dec;
  logic              full_q, empty_q;

  // modulo-depth wrap falls out of the fixed width
  assign sp_inc = sp_q + 1'b1;
  assign sp_dec = sp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      unique case (op_i)
        OP_PUSH: begin
          sp_q    <= sp_inc;
          full_q  <= (sp_inc == '0);
          empty_q <= 1'b0;
        end
        OP_POP: begin
          sp_q    <= sp_dec;
          empty_q <= (sp_dec == '0);
          full_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign sp_o     = sp_q;
  assign wr_ptr_o = sp_inc;
  assign full_o   = full_q;
  assign empty_o  = empty_q;
endmodule

// File: rtl/wstk_regfile.sv
`timescale 1ns/1ps
module wstk_regfile #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  wr_sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_wsel
    assign wr_sel[g] = we_i && (waddr_i == ADDR_W'(g));
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_sel[i]) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wrap_reg_stack.sv
`timescale 1ns/1ps
module wrap_reg_stack
  import wstk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  stk_op_e           op;
  logic [ADDR_W-1:0] sp_w, wr_ptr;
  logic [DATA_W-1:0] top_word, dr_q;
  logic              full_w, empty_w, err_q;

  wstk_op_dec u_dec (
    .push_i  (push_i),
    .pop_i   (pop_i),
    .full_i  (full_w),
    .empty_i (empty_w),
    .op_o    (op)
  );

  wstk_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .sp_o     (sp_w),
    .wr_ptr_o (wr_ptr),
    .full_o   (full_w),
    .empty_o  (empty_w)
  );

  // push writes at sp+1, pop reads at sp
  wstk_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk_i   (clk_i),
    .we_i    (op == OP_PUSH),
    .waddr_i (wr_ptr),
    .wdata_i (wdata_i),
    .raddr_i (sp_w),
    .rdata_o (top_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (op == OP_POP) dr_q <= top_word;
      err_q <= (op == OP_ILLEGAL);
    end
  end

  assign rdata_o = dr_q;
  assign full_o  = full_w;
  assign empty_o = empty_w;
  assign err_o   = err_q;
endmodule

// File: rtl/wrap_reg_stack_chk.sv
`timescale 1ns/1ps
module wrap_reg_stack_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] sp_w
);
  // R4
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  // R5
  full_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (sp_w == '0));

  // R3
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i || push_i || empty_o) |=> $stable(rdata_o));

  // R4
  push_clears_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=> !empty_o);

  // R6
  pop_clears_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> !full_o);

  // R7
  push_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> (full_o && err_o && $stable(sp_w)));

  // R8
  pop_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> (empty_o && err_o && $stable(rdata_o)));

  // R9
  both_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> (err_o && $stable(sp_w) && $stable(full_o) && $stable(empty_o)));

  // R10
  no_err_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> !err_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> ($stable(sp_w) && $stable(full_o) && $stable(empty_o)));
endmodule

bind wrap_reg_stack wrap_reg_stack_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .rdata_o (rdata_o),
  .full_o  (full_o),
  .empty_o (empty_o),
  .err_o   (err_o),
  .sp_w    (sp_w)
);

// File: tb/wrap_reg_stack_test.sv
`timescale 1ns/1ps
module wrap_reg_stack_test;
  localparam int DW    = 16;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          full;
    logic          empty;
    logic          err;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          full_o, empty_o, err_o;

  int checks = 0;
  int errors = 0;

  exp_t          exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] model_q[$];
  logic [DW-1:0] model_dr = '0;

  always #2 clk = ~clk;

  wrap_reg_stack #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .err_o   (err_o)
  );

  task automatic chk(input string tag, input string what, input logic [DW-1:0] got, exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // driver: one command per cycle, expectation queued for the monitor
  task automatic step(input logic ps, input logic pp, input logic [DW-1:0] d, input string tag);
    exp_t e;
    logic bad;
    @(negedge clk);
    push_i  = ps;
    pop_i   = pp;
    wdata_i = d;
    bad = (ps && pp) || (ps && model_q.size() == DEPTH) || (pp && model_q.size() == 0);
    if (!bad && ps) model_q.push_back(d);
    if (!bad && pp) model_dr = model_q.pop_back();
    e.data  = model_dr;
    e.full  = (model_q.size() == DEPTH);
    e.empty = (model_q.size() == 0);
    e.err   = bad;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    push_i = 1'b0;
    pop_i  = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "rdata", rdata_o, e.data);
      chk(t, "full",  DW'(full_o),  DW'(e.full));
      chk(t, "empty", DW'(empty_o), DW'(e.empty));
      chk(t, "err",   DW'(err_o),   DW'(e.err));
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "rdata", rdata_o, '0);
    chk("R1", "full",  DW'(full_o),  '0);
    chk("R1", "empty", DW'(empty_o), DW'(1));
    chk("R1", "err",   DW'(err_o),   '0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R4 push clears empty; R3 push leaves rdata
    step(1, 0, 16'hA001, "R4");
    step(1, 0, 16'hA002, "R3");
    step(1, 0, 16'hA003, "R3");
    // R11 idle holds, R10 no error
    step(0, 0, 16'h0000, "R11");
    step(0, 0, 16'h0000, "R10");
    // R2 LIFO order
    step(0, 1, 16'h0000, "R2");
    step(1, 0, 16'hA004, "R2");
    step(0, 1, 16'h0000, "R2");
    step(0, 1, 16'h0000, "R2");
    // R9 both strobes on a non-empty stack
    step(1, 1, 16'hBEEF, "R9");
    step(0, 0, 16'h0000, "R10");
    step(0, 1, 16'h0000, "R4");
    // R8 pop on empty, repeated
    step(0, 1, 16'h0000, "R8");
    step(0, 1, 16'h0000, "R8");
    step(0, 0, 16'h0000, "R10");
    // R9 both strobes on empty
    step(1, 1, 16'hCAFE, "R9");
    // R5 fill to the wrap
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, DW'(16'h1000 + i), (i == DEPTH - 1) ? "R5" : "R2");
    // R7 push while full
    step(1, 0, 16'hDEAD, "R7");
    step(1, 0, 16'hDEAD, "R7");
    step(0, 0, 16'h0000, "R11");
    // R6 drain in reverse, word 0 first
    for (int i = 0; i < DEPTH; i++)
      step(0, 1, 16'h0000, (i == DEPTH - 1) ? "R4" : "R6");
    step(0, 1, 16'h0000, "R8");
    // second round after full drain
    step(1, 0, 16'h5A5A, "R4");
    step(0, 1, 16'h0000, "R2");
    step(0, 0, 16'h0000, "R10");
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule